// File: doc/BRIEF.md
# Double-Buffered PWM Compare Channel

This block produces one pulse-width-modulated output from the low byte of a free-running counter that other logic owns and shares. Each cycle the counter byte is compared against an active duty register. The output is low while the count is below that register and high once the count reaches or passes it. So the duty value sets how much of each 256-count period the pin spends low.

Software never writes the active register directly. A write goes into a shadow register through a small valid/ready port. The shadow value moves into the active register only at the edge where the counter steps from its all-ones value back to zero. A period that has already started always finishes with the duty it started with, so the output never shows a runt or stretched pulse.

Two mode bits must both be set for the channel to run. With either bit clear, the pin rests high and the active register keeps its value, while the shadow can still be written.

Top module: `pwm_glitchfree_ch`

## Requirements
- R1: While enabled and the counter byte is less than the active duty value, `pwm_out` is 0.
- R2: While enabled and the counter byte is equal to or greater than the active duty value, `pwm_out` is 1. The comparison is an unsigned 8-bit magnitude compare.
- R3: At a clock edge where the channel is enabled, `cnt_run` is 1 and `cnt_lo` is 8'hFF, the active duty value takes the shadow value. The new duty applies from count 8'h00 onward.
- R4: The channel is enabled only when `cmp_en` and `pwm_en` are both 1. Either bit alone leaves the channel disabled.
- R5: A shadow write leaves the duty of the running period unchanged. Its value first acts after the next wrap.
- R6: While disabled, `pwm_out` is 1 and the active duty value does not change, even across a counter wrap.
- R7: A write accepted at the same edge as a wrap stores its data in the shadow. The active value takes the shadow value held before that edge, and the new data acts only after the following wrap.
- R8: After reset, both the shadow and active duty values are 8'h00, so an enabled channel drives `pwm_out` high at every count.
- R9: With an active duty of 8'hFF, `pwm_out` is low for counts 8'h00 to 8'hFE and high only at 8'hFF.
- R10: Cycles where `cnt_run` is 0 are never a wrap, even when `cnt_lo` is 8'hFF.
- R11: `wr_ready` is always 1. Every cycle with `wr_valid` at 1 writes `wr_data` into the shadow, and the last write before a wrap wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_lo | input | 8 | Low byte of the shared counter |
| cnt_run | input | 1 | Counter advances at this edge |
| wr_valid | input | 1 | Shadow write request |
| wr_ready | output | 1 | Shadow write accepted (constant 1) |
| wr_data | input | 8 | New duty value for the shadow |
| cmp_en | input | 1 | Comparator enable mode bit |
| pwm_en | input | 1 | PWM mode bit |
| pwm_out | output | 1 | PWM pin |

## Verification
The edge assertions on `pwm_out` assume a well-behaved counter. `cnt_lo` may change only at an edge where `cnt_run` was 1, and then only to its value plus one modulo 256. Under that assumption a rising output can only occur at the count equal to the duty value, and a falling output only at count zero. The bench therefore drives `cnt_lo` from its own counter register, which increments only when the bench raises `cnt_run`. Mode bits stay low through reset, and the bench changes them only between edges.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    MODE_OFF      = 2'b00,
    MODE_CMP_ONLY = 2'b01,
    MODE_PWM_ONLY = 2'b10,
    MODE_RUN      = 2'b11
  } pwm_mode_t;

  function automatic pwm_mode_t mode_of(input logic cmp_bit, input logic pwm_bit);
    return pwm_mode_t'({pwm_bit, cmp_bit});
  endfunction
endpackage

// File: rtl/pwm_mode_dec.sv
module pwm_mode_dec
  import pwm_pkg::*;
(
  input  logic cmp_en_i,
  input  logic pwm_en_i,
  output logic run_en_o
);
  pwm_mode_t mode;

  always_comb begin
    mode     = mode_of(cmp_en_i, pwm_en_i);
    run_en_o = (mode == MODE_RUN);
  end
endmodule

// File: rtl/pwm_wrap_det.sv
module pwm_wrap_det #(
  parameter int CNT_W = 8
) (
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Wrap is the counter stepping from all ones to zero, seen only on a run cycle.
  always_comb wrap_o = run_i && (cnt_i == CNT_MAX);
endmodule

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf #(
  parameter int               CNT_W      = 8,
  parameter logic [CNT_W-1:0] RESET_DUTY = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] active_o
);
  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= RESET_DUTY;
      active_q <= RESET_DUTY;
    end else begin
      if (wr_valid_i) shadow_q <= wr_data_i;
      if (load_i)     active_q <= shadow_q;
    end
  end

  assign active_o = active_q;

  // R3: transfer at a wrap
  a_r3_load_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> active_q == $past(shadow_q));
  // R5 / R6: active duty frozen between wraps and while disabled
  a_r6_hold_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(active_q));
  // R7: simultaneous write and wrap
  a_r7_write_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && wr_valid_i) |=> (shadow_q == $past(wr_data_i)) && (active_q == $past(shadow_q)));
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             run_en_i,
  output logic             pwm_o
);
  logic below;

  always_comb begin
    below = (cnt_i < duty_i);
    pwm_o = run_en_i ? !below : 1'b1;
  end
endmodule

// File: rtl/pwm_glitchfree_ch.sv
module pwm_glitchfree_ch #(
  parameter int               CNT_W      = 8,
  parameter logic [CNT_W-1:0] RESET_DUTY = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_lo,
  input  logic             cnt_run,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cmp_en,
  input  logic             pwm_en,
  output logic             pwm_out
);
  logic             run_en;
  logic             wrap;
  logic [CNT_W-1:0] active;

  assign wr_ready = 1'b1;

  pwm_mode_dec u_mode (
    .cmp_en_i (cmp_en),
    .pwm_en_i (pwm_en),
    .run_en_o (run_en)
  );

  pwm_wrap_det #(.CNT_W(CNT_W)) u_wrap (
    .run_i  (cnt_run),
    .cnt_i  (cnt_lo),
    .wrap_o (wrap)
  );

  pwm_duty_buf #(.CNT_W(CNT_W), .RESET_DUTY(RESET_DUTY)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid_i (wr_valid),
    .wr_data_i  (wr_data),
    .load_i     (wrap && run_en),
    .active_o   (active)
  );

  pwm_cmp #(.CNT_W(CNT_W)) u_cmp (
    .cnt_i    (cnt_lo),
    .duty_i   (active),
    .run_en_i (run_en),
    .pwm_o    (pwm_out)
  );

  // R1: with a counter that steps by one, a rise lands exactly on the duty count
  a_r1_rise_at_duty: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwm_out) && run_en && $past(run_en)) |-> cnt_lo == active);
  // R2 / R5: a fall can only come at the start of a period
  a_r2_fall_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwm_out) && run_en && $past(run_en)) |-> cnt_lo == '0);
  // R11: write port never back-pressures
  a_r11_ready: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);
endmodule

// File: tb/pwm_glitchfree_ch_tb_top.sv
module pwm_glitchfree_ch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cnt = 8'h00;
  logic       run = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = 8'h00;
  logic       cmp_en = 1'b0;
  logic       pwm_en = 1'b0;
  logic       pwm_out;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cnt <= 8'h00;
    else if (run) cnt <= cnt + 8'h01;
  end

  pwm_glitchfree_ch dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_lo(cnt), .cnt_run(run),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .cmp_en(cmp_en), .pwm_en(pwm_en), .pwm_out(pwm_out)
  );

  // {duty, probe count, expected pin}: R1, R2, R9
  localparam logic [16:0] VEC [10] = '{
    {8'h80, 8'h7F, 1'b0}, {8'h80, 8'h80, 1'b1}, {8'h80, 8'h00, 1'b0},
    {8'h01, 8'h00, 1'b0}, {8'h01, 8'h01, 1'b1}, {8'h00, 8'h00, 1'b1},
    {8'hFF, 8'hFE, 1'b0}, {8'hFF, 8'hFF, 1'b1}, {8'h40, 8'hC0, 1'b1},
    {8'h40, 8'h3F, 1'b0}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cnt=%02h actual=%b expected=%b", req, cnt, act, exp);
    end
  endtask

  task automatic run_to(input logic [7:0] c);
    while (cnt != c) step();
  endtask

  task automatic write_shadow(input logic [7:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic pass_wrap();
    run_to(8'hFF);
    step();
  endtask

  initial begin
    #(5 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) step();
    rst_n = 1'b1;
    cmp_en = 1'b1;
    pwm_en = 1'b1;
    run = 1'b1;
    #0;
    // R8: reset duty 0 keeps the pin high
    check("R8", pwm_out, 1'b1);
    check("R11", wr_ready, 1'b1);
    run_to(8'h80);
    check("R8", pwm_out, 1'b1);
    pass_wrap();
    run_to(8'h05);
    check("R8", pwm_out, 1'b1);

    // Vector table
    for (int i = 0; i < 10; i++) begin
      write_shadow(VEC[i][16:9]);
      pass_wrap();
      run_to(VEC[i][8:1]);
      check(VEC[i][16:9] == 8'hFF ? "R9" : (VEC[i][0] ? "R2" : "R1"), pwm_out, VEC[i][0]);
    end

    // R5: write mid-period does not alter the current period
    write_shadow(8'h80);
    pass_wrap();
    run_to(8'h10);
    write_shadow(8'h20);
    run_to(8'h30);
    check("R5", pwm_out, 1'b0);
    pass_wrap();
    run_to(8'h30);
    check("R3", pwm_out, 1'b1);

    // R4 / R6: one mode bit alone disables, active frozen
    pwm_en = 1'b0;
    run_to(8'h10);
    check("R4", pwm_out, 1'b1);
    cmp_en = 1'b0;
    pwm_en = 1'b1;
    step();
    check("R4", pwm_out, 1'b1);
    write_shadow(8'h90);
    pwm_en = 1'b0;
    cmp_en = 1'b1;
    pass_wrap();
    run_to(8'h10);
    check("R6", pwm_out, 1'b1);
    pwm_en = 1'b1;
    run_to(8'h50);
    check("R6", pwm_out, 1'b1);
    pass_wrap();
    run_to(8'h50);
    check("R3", pwm_out, 1'b0);

    // R7: write landing on the wrap edge
    run_to(8'hFF);
    write_shadow(8'h10);
    check("R11", wr_ready, 1'b1);
    run_to(8'h50);
    check("R7", pwm_out, 1'b0);
    pass_wrap();
    run_to(8'h50);
    check("R7", pwm_out, 1'b1);

    // R10: stalled at FF is not a wrap
    run_to(8'hFF);
    run = 1'b0;
    step();
    write_shadow(8'h80);
    step();
    step();
    pwm_en = 1'b0;
    run = 1'b1;
    step();
    run_to(8'h08);
    pwm_en = 1'b1;
    run_to(8'h40);
    check("R10", pwm_out, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule